// File: doc/BRIEF.md
# SPI EEPROM Command Controller

This block is the slave side of a serial memory with a 2048 x 8 array. It accepts SPI mode 0 and mode 3 traffic on chip-select, serial clock and serial data in, and answers on a serial data out pin that has its own output enable. All pins are brought into the system clock domain through two-flop synchronizers, and the edges are detected there. For that reason the serial clock must stay well below the system clock; the bench uses one sixteenth of it.

Each transaction begins with an 8-bit opcode. The block keeps a status byte that holds the protection and lock bits, a software flag, the write-enable latch and a busy bit. It gathers the bytes of a page write in a local page buffer. Any change to the array or to the status register is committed only when chip-select rises exactly on a byte boundary. After the commit, a self-timed cycle counted in system clocks runs, and during that cycle the busy bit reads 1. The array and the persistent status bits are held in flops.

Top module: `eep_spi_ctrl`

## Requirements
- R1: Serial input bits are sampled on rising SCK and output bits change on falling SCK, MSB first. Behaviour is the same whether SCK idles low or high. `so_oe_o` is 0 while chip-select is high and during the opcode byte. It is 1 only while a read or status response is being shifted.
- R2: After reset, no command takes effect until a falling edge of `cs_ni` has been seen. Bits clocked while chip-select was already low at reset are ignored.
- R3: The one-byte commands act only when chip-select rises after exactly 8 bits:
  - 0x06 sets WEL.
  - 0x04 clears both WEL and FLB.
  - 0x00 sets FLB.
- R4: Opcode 0x05 returns the status byte {WPEN, FLB, 0, 0, BL1, BL0, WEL, WIP}, bit 7 first. The byte is re-sent for as long as clocks continue, and the command works during a write cycle.
- R5: Opcode 0x03 is followed by a 16-bit address, of which only bits 10:0 are used. It then streams array bytes with auto-increment, wrapping from 0x7FF to 0x000.
- R6: Opcode 0x02 is followed by a 16-bit address and one or more data bytes. It commits only if WEL is 1 and chip-select rises right after bit 0 of a data byte. Otherwise the array and WIP are left unchanged.
- R7: Write data fills a 32-byte page. The address wraps to the start of the page after the last byte of the page.
- R8: After a commit, WIP reads 1 for the parameterised number of system clocks. When the cycle ends, WIP and WEL both read 0.
- R9: While WIP is 1, every opcode other than 0x05 is ignored.
- R10: BL1:BL0 set the write-protected range: 00 protects nothing, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF and 11 protects the whole array. A write to a protected page starts no cycle and leaves WEL set, but the page can still be read.
- R11: Opcode 0x01 followed by one byte needs WEL and loads WPEN from bit 7 and BL1:BL0 from bits 3:2. All other data bits are ignored. The write is refused while WPEN=1 and `wp_ni` is low. A status cycle that has already started completes even if `wp_ni` falls during it.
- R12: Reset clears the array, every status bit and `so_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; drives the synchronizers, the logic and the write timer |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Status lock pin, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` |

## Verification
The hardest case to reach is a status write that commits while `wp_ni` is high, followed by `wp_ni` falling while the busy cycle runs. The bench reaches it by driving `wp_ni` low in the first system clocks after the chip-select rise that commits the write. It then checks that the cycle still installs WPEN, and that the next status write is refused while WEL is left set. Aborted writes are exercised as well: the bench stops chip-select a few bits into a data byte and confirms that nothing changes. Both opcodes and writes are also sent during a busy cycle, and the bench confirms they are ignored.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_SFLAG  = 8'h00;
  localparam logic [7:0] OP_WRSTAT = 8'h01;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRDIS  = 8'h04;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;

  typedef struct packed {
    logic wren;
    logic wrdis;
    logic sflag;
    logic wrstat;
    logic page_wr;
  } cmd_pulse_t;

  // top2 = two most significant address bits
  function automatic logic zone_locked(input logic [1:0] bl, input logic [1:0] top2);
    case (bl)
      2'b00:   zone_locked = 1'b0;
      2'b01:   zone_locked = (top2 == 2'b11);
      2'b10:   zone_locked = top2[1];
      default: zone_locked = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_sync
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~s3_q;
    assign fall_o[g] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
  import eep_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 5,
  localparam int PB = 1 << PW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_fall_i,
  input  logic                 cs_rise_i,
  input  logic                 sck_rise_i,
  input  logic                 sck_fall_i,
  input  logic                 si_i,
  input  logic                 busy_i,
  input  logic [7:0]           status_i,
  input  logic [7:0]           rd_data_i,
  output logic [AW-1:0]        rd_addr_o,
  output cmd_pulse_t           cmd_o,
  output logic [2:0]           wrstat_o,
  output logic [AW-PW-1:0]     page_base_o,
  output logic [PB-1:0][7:0]   page_data_o,
  output logic [PB-1:0]        page_mask_o,
  output logic                 so_o,
  output logic                 so_oe_o
);
  logic active, opc_ok, tx_valid, so_q;
  logic [2:0] bit_cnt, byte_cnt;
  logic [7:0] sh, opc, hi, tx_byte;
  logic [2:0] wrstat_q;
  logic [AW-1:0] ptr;
  logic [PB-1:0][7:0] buf_q;
  logic [PB-1:0] mask_q;
  cmd_pulse_t cmd_q;

  logic [7:0] nxt;
  logic [15:0] full_addr;
  logic aligned;
  assign nxt       = {sh[6:0], si_i};
  assign full_addr = {hi, nxt};
  assign rd_addr_o = (byte_cnt == 3'd2) ? full_addr[AW-1:0] : ptr;
  assign aligned   = active & opc_ok & (bit_cnt == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0; opc_ok <= 1'b0; tx_valid <= 1'b0; so_q <= 1'b0;
      bit_cnt <= '0; byte_cnt <= '0; sh <= '0; opc <= '0; hi <= '0;
      tx_byte <= '0; wrstat_q <= '0; ptr <= '0; buf_q <= '0; mask_q <= '0;
      cmd_q <= '0;
    end else begin
      cmd_q <= '0;
      if (cs_fall_i) begin
        active <= 1'b1; opc_ok <= 1'b0; tx_valid <= 1'b0;
        bit_cnt <= '0; byte_cnt <= '0; mask_q <= '0;
      end else if (cs_rise_i) begin
        cmd_q.wren    <= aligned & (opc == OP_WREN)   & (byte_cnt == 3'd1);
        cmd_q.wrdis   <= aligned & (opc == OP_WRDIS)  & (byte_cnt == 3'd1);
        cmd_q.sflag   <= aligned & (opc == OP_SFLAG)  & (byte_cnt == 3'd1);
        cmd_q.wrstat  <= aligned & (opc == OP_WRSTAT) & (byte_cnt == 3'd2);
        cmd_q.page_wr <= aligned & (opc == OP_WRITE)  & (byte_cnt >= 3'd4);
        active <= 1'b0; tx_valid <= 1'b0;
      end else if (active) begin
        if (sck_rise_i) begin
          sh <= nxt;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_cnt <= byte_cnt + ((byte_cnt != 3'd7) ? 3'd1 : 3'd0);
            if (byte_cnt == 3'd0) begin
              opc <= nxt;
              opc_ok <= ~busy_i | (nxt == OP_RDSTAT);
              if (nxt == OP_RDSTAT) begin
                tx_byte <= status_i; tx_valid <= 1'b1;
              end
            end else if (opc_ok) begin
              if (opc == OP_RDSTAT) tx_byte <= status_i;
              if (byte_cnt == 3'd1) begin
                hi <= nxt;
                wrstat_q <= {nxt[7], nxt[3:2]};
              end else if (byte_cnt == 3'd2) begin
                ptr <= full_addr[AW-1:0];
                if (opc == OP_READ) begin
                  tx_byte <= rd_data_i; tx_valid <= 1'b1;
                  ptr <= full_addr[AW-1:0] + AW'(1);
                end
              end else if (opc == OP_READ) begin
                tx_byte <= rd_data_i;
                ptr <= ptr + AW'(1);
              end else if (opc == OP_WRITE) begin
                buf_q[ptr[PW-1:0]]  <= nxt;
                mask_q[ptr[PW-1:0]] <= 1'b1;
                ptr[PW-1:0] <= ptr[PW-1:0] + PW'(1);   // wrap inside page
              end
            end
          end
        end
        if (sck_fall_i && tx_valid) so_q <= tx_byte[3'd7 - bit_cnt];
      end
    end
  end

  assign cmd_o       = cmd_q;
  assign wrstat_o    = wrstat_q;
  assign page_base_o = ptr[AW-1:PW];
  assign page_data_o = buf_q;
  assign page_mask_o = mask_q;
  assign so_o        = so_q;
  assign so_oe_o     = active & tx_valid;

  p_one_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_q));
  p_commit_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.page_wr |-> ($past(bit_cnt) == 3'd0));
  p_oe_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !so_oe_o);
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 5,
  parameter int WR_CYCLES = 625000,
  localparam int DEPTH = 1 << AW,
  localparam int PB = 1 << PW,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cmd_pulse_t         cmd_i,
  input  logic [2:0]         wrstat_i,
  input  logic [AW-PW-1:0]   page_base_i,
  input  logic [PB-1:0][7:0] page_data_i,
  input  logic [PB-1:0]      page_mask_i,
  input  logic               wp_n_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [7:0]         rd_data_o,
  output logic [7:0]         status_o,
  output logic               busy_o
);
  logic [7:0] mem_q [DEPTH];
  logic wel_q, flb_q, wpen_q;
  logic [1:0] bl_q;
  logic [CW-1:0] cnt_q;
  logic wip, page_ok, sr_ok;

  assign wip     = (cnt_q != '0);
  assign page_ok = cmd_i.page_wr & wel_q & ~wip
                 & ~zone_locked(bl_q, page_base_i[AW-PW-1 -: 2]);
  assign sr_ok   = cmd_i.wrstat & wel_q & ~wip & ~(wpen_q & ~wp_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0; flb_q <= 1'b0; wpen_q <= 1'b0; bl_q <= '0; cnt_q <= '0;
    end else begin
      if (page_ok || sr_ok) cnt_q <= CW'(WR_CYCLES);
      else if (wip) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) wel_q <= 1'b0;
      end
      if (sr_ok) begin
        wpen_q <= wrstat_i[2];
        bl_q   <= wrstat_i[1:0];
      end
      if (cmd_i.wren)  wel_q <= 1'b1;
      if (cmd_i.wrdis) begin wel_q <= 1'b0; flb_q <= 1'b0; end
      if (cmd_i.sflag) flb_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (page_ok) begin
      for (int k = 0; k < PB; k++)
        if (page_mask_i[k]) mem_q[{page_base_i, PW'(k)}] <= page_data_i[k];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign status_o  = {wpen_q, flb_q, 2'b00, bl_q, wel_q, wip};
  assign busy_o    = wip;

  p_wip_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> $past(cmd_i.wrstat | cmd_i.page_wr));
  p_wel_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip) |-> !wel_q);
  p_zone_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.page_wr && !wip && zone_locked(bl_q, page_base_i[AW-PW-1 -: 2])) |=> !wip);
  p_stat_lock_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.wrstat && wpen_q && !wp_n_i && !wip) |=> ($stable({wpen_q, bl_q}) && !wip));
endmodule

// File: rtl/eep_spi_ctrl.sv
module eep_spi_ctrl
  import eep_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 5,
  parameter int WR_CYCLES = 625000,
  localparam int PB = 1 << PW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic wp_ni,
  output logic so_o,
  output logic so_oe_o
);
  logic [3:0] lvl, rise, fall;
  cmd_pulse_t cmd;
  logic [2:0] wrstat;
  logic [AW-PW-1:0] page_base;
  logic [PB-1:0][7:0] page_data;
  logic [PB-1:0] page_mask;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data, status;
  logic busy;

  eep_pin_sync #(.N(4)) u_sync (
    .clk_i, .rst_ni,
    .pin_i ({wp_ni, si_i, sck_i, cs_ni}),
    .lvl_o (lvl), .rise_o (rise), .fall_o (fall)
  );

  eep_cmd_engine #(.AW(AW), .PW(PW)) u_engine (
    .clk_i, .rst_ni,
    .cs_fall_i (fall[0]), .cs_rise_i (rise[0]),
    .sck_rise_i (rise[1]), .sck_fall_i (fall[1]),
    .si_i (lvl[2]), .busy_i (busy), .status_i (status), .rd_data_i (rd_data),
    .rd_addr_o (rd_addr), .cmd_o (cmd), .wrstat_o (wrstat),
    .page_base_o (page_base), .page_data_o (page_data), .page_mask_o (page_mask),
    .so_o, .so_oe_o
  );

  eep_store #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk_i, .rst_ni,
    .cmd_i (cmd), .wrstat_i (wrstat), .page_base_i (page_base),
    .page_data_i (page_data), .page_mask_i (page_mask), .wp_n_i (lvl[3]),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data), .status_o (status), .busy_o (busy)
  );
endmodule

// File: tb/eep_spi_ctrl_tb.sv
module eep_spi_ctrl_tb_top;
  localparam int WR = 1500;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  always #4 clk = ~clk;

  eep_spi_ctrl #(.WR_CYCLES(WR)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .sck_i (sck), .si_i (si),
    .wp_ni (wp_n), .so_o (so), .so_oe_o (so_oe)
  );

  int n_cmp = 0, n_err = 0;
  bit done = 0, mode3 = 0;
  logic [7:0] m_mem [2048];
  bit m_wel = 0, m_flb = 0, m_wpen = 0, m_busy = 0;
  logic [1:0] m_bl = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_stat();
    return {m_wpen, m_flb, 2'b00, m_bl, m_wel, m_busy};
  endfunction

  function automatic bit locked(input logic [10:0] a);
    return (m_bl == 2'd3) || (m_bl == 2'd2 && a[10]) || (m_bl == 2'd1 && a[10:9] == 2'b11);
  endfunction

  task automatic sel();
    sck = mode3; tick(HP); cs_n = 1'b0; tick(HP);
  endtask

  task automatic desel();
    tick(HP); cs_n = 1'b1; tick(2 * HP);
  endtask

  task automatic clk_bit(input logic b, output logic r, output logic oe);
    if (mode3) sck = 1'b0;
    si = b; tick(HP);
    r = so; oe = so_oe;
    sck = 1'b1; tick(HP);
    if (!mode3) sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe_any);
    logic r, oe;
    oe_any = 0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(tx[i], r, oe);
      rx[i] = r;
      if (oe) oe_any = 1;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] rx; bit oe;
    sel(); xfer(op, rx, oe); desel();
    if (!m_busy) begin
      if (op == 8'h06) m_wel = 1;
      if (op == 8'h04) begin m_wel = 0; m_flb = 0; end
      if (op == 8'h00) m_flb = 1;
    end
  endtask

  task automatic wait_done();
    if (m_busy) begin
      tick(WR + 60);
      m_busy = 0; m_wel = 0;
    end
  endtask

  task automatic rdsr_chk(input string tag);
    logic [7:0] rx; bit oe;
    sel();
    xfer(8'h05, rx, oe);
    chk({tag, " oe off during opcode (R1)"}, oe, 1'b0);
    xfer(8'h00, rx, oe);
    chk({tag, " status (R4)"}, rx, exp_stat());
    chk({tag, " oe on during response (R1)"}, oe, 1'b1);
    xfer(8'h00, rx, oe);
    chk({tag, " status repeat (R4)"}, rx, exp_stat());
    desel();
    chk({tag, " oe off after deselect (R1)"}, so_oe, 1'b0);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] d [8], input int extra);
    logic [7:0] rx; logic r, oe; bit oa;
    sel();
    xfer(8'h02, rx, oa); xfer(a[15:8], rx, oa); xfer(a[7:0], rx, oa);
    for (int k = 0; k < n; k++) xfer(d[k], rx, oa);
    for (int j = 0; j < extra; j++) clk_bit(1'b1, r, oe);
    desel();
    if (!m_busy && m_wel && extra == 0 && n >= 1 && !locked(a[10:0])) begin
      for (int k = 0; k < n; k++)
        m_mem[{a[10:5], 5'(a[4:0] + 5'(k))}] = d[k];
      m_busy = 1;
    end
  endtask

  task automatic read_chk(input logic [15:0] a, input int n, input string tag);
    logic [7:0] rx; bit oe;
    sel();
    xfer(8'h03, rx, oe); xfer(a[15:8], rx, oe); xfer(a[7:0], rx, oe);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx, oe);
      chk($sformatf("%s byte %0d", tag, k), rx, m_mem[11'(a[10:0] + 11'(k))]);
    end
    desel();
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [7:0] rx; bit oe;
    sel(); xfer(8'h01, rx, oe); xfer(d, rx, oe); desel();
    if (!m_busy && m_wel && !(m_wpen && !wp_n)) begin
      m_wpen = d[7]; m_bl = d[3:2]; m_busy = 1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d [8];
    logic [7:0] rx; bit oe;
    for (int i = 0; i < 2048; i++) m_mem[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);
    chk("reset oe off (R12)", so_oe, 1'b0);

    // R2: clocks while CS was low through reset are ignored
    xfer(8'h06, rx, oe); tick(HP); cs_n = 1'b1; tick(2 * HP);
    rdsr_chk("R2 no arm before CS fall / R12 reset status");
    read_chk(16'h0000, 1, "R12 array cleared");

    // R3 one-byte commands
    cmd1(8'h06); rdsr_chk("R3 wren");
    cmd1(8'h00); rdsr_chk("R3 sflag");
    cmd1(8'h04); rdsr_chk("R3 wrdis clears wel and flag");
    sel(); xfer(8'h06, rx, oe); xfer(8'h00, rx, oe); desel();
    rdsr_chk("R3 wren with extra byte ignored");

    // R6 write without WEL
    d = '{8'hAA, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h0010, 1, d, 0);
    rdsr_chk("R6 no wel no cycle");
    read_chk(16'h0010, 1, "R6 no wel array unchanged");

    // R8 normal write + timing
    cmd1(8'h06);
    d = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
    do_write(16'h0020, 3, d, 0);
    rdsr_chk("R8 wip during cycle");
    wait_done();
    rdsr_chk("R8 wip and wel clear after cycle");
    read_chk(16'h0020, 3, "R5 R1 read back");

    // R6 abort mid byte
    cmd1(8'h06);
    d = '{8'h55, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h0040, 1, d, 3);
    rdsr_chk("R6 abort keeps wel, no wip");
    read_chk(16'h0040, 1, "R6 abort array unchanged");

    // R7 page wrap
    d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 0, 0, 0, 0};
    do_write(16'h005E, 4, d, 0);
    wait_done();
    read_chk(16'h005E, 3, "R7 page tail and next page untouched");
    read_chk(16'h0040, 2, "R7 wrapped to page start");

    // R9 busy ignore, R4 during busy
    cmd1(8'h06);
    d = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h07FF, 1, d, 0);
    cmd1(8'h00);
    rdsr_chk("R4 R9 status during busy");
    d = '{8'hEE, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h0100, 1, d, 0);
    wait_done();
    rdsr_chk("R9 flag unchanged after busy");
    read_chk(16'h0100, 1, "R9 write during busy ignored");
    cmd1(8'h06);
    d = '{8'hC3, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h0000, 1, d, 0);
    wait_done();
    read_chk(16'h07FF, 2, "R5 wrap top to zero");
    read_chk(16'hF820, 2, "R5 upper address bits ignored");

    // R11 status writes
    cmd1(8'h06); wrsr(8'h8F); wait_done();
    rdsr_chk("R11 wrsr field mask");
    cmd1(8'h06); wrsr(8'h00); wait_done();
    rdsr_chk("R11 wrsr with wpen and wp high");
    cmd1(8'h06); wrsr(8'h88);
    wp_n = 1'b0;
    wait_done();
    rdsr_chk("R11 in-flight write completes");
    cmd1(8'h06); wrsr(8'h00); tick(200);
    rdsr_chk("R11 locked refuses, wel kept");
    wp_n = 1'b1;
    wrsr(8'h04); wait_done();
    rdsr_chk("R11 unlock via pin, bl=01");

    // R10 zones
    cmd1(8'h06);
    d = '{8'h77, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h05FF, 1, d, 0); wait_done();
    cmd1(8'h06);
    d = '{8'h99, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h0600, 1, d, 0);
    rdsr_chk("R10 bl01 blocked keeps wel");
    read_chk(16'h05FF, 2, "R10 bl01 boundary");
    cmd1(8'h06); wrsr(8'h08); wait_done();
    cmd1(8'h06);
    d = '{8'h12, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h03FF, 1, d, 0); wait_done();
    cmd1(8'h06);
    d = '{8'h34, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h0400, 1, d, 0);
    read_chk(16'h03FF, 2, "R10 bl10 boundary");
    wrsr(8'h0C); wait_done();
    cmd1(8'h06);
    d = '{8'h56, 0, 0, 0, 0, 0, 0, 0};
    do_write(16'h0000, 1, d, 0);
    read_chk(16'h0000, 1, "R10 bl11 whole array");
    wrsr(8'h00); wait_done();
    rdsr_chk("R10 zones cleared");

    // R1 mode 3
    mode3 = 1;
    rdsr_chk("R1 mode3 status");
    cmd1(8'h06);
    d = '{8'hE1, 8'hE2, 0, 0, 0, 0, 0, 0};
    do_write(16'h0100, 2, d, 0); wait_done();
    read_chk(16'h0100, 2, "R1 mode3 write/read");
    read_chk(16'h0020, 3, "R1 mode3 read");
    mode3 = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule